// File: doc/BRIEF.md
# Modulo-Scheduled Loop Controller

This block supplies the hardware state behind a software-pipelined loop. It holds a loop counter and an epilog counter, a bank of rotating stage predicates and a base offset for a rotating window of general registers. The loop body ends in a single closing branch. That branch counts the kernel iterations and then drains the pipeline stages that are still in flight, so the compiler does not have to unroll a prologue or an epilog.

Software first loads the two counters and the initial predicate pattern. The usual starting pattern has only the first stage predicate set. Each pulse on the branch strobe is one execution of the closing branch. The block answers in the same cycle with the taken decision. On the clock edge that ends the strobe cycle it updates the counters, shifts a new stage bit into the first predicate, and moves the register base down by one. One physical register written in one iteration therefore appears under the next logical name after each rotation. Here is a worked case: a loop count of 199 and an epilog count of 4 give 202 taken branches followed by one fall-through. Instruction fetch and the register file itself sit outside the block.

Top module: `msl_loop_ctrl`

## Requirements
- R1: After reset the rotating base reads 0, every stage predicate reads 0, and both counters hold 0. A strobe in that state is therefore not taken.
- R2: `br_taken` is combinational. It is 1 only in a cycle where `br_strobe` is 1 and either the loop count is nonzero or the epilog count is greater than 1.
- R3: On a strobe with a nonzero loop count, the loop count decrements by 1, the epilog count is unchanged, and a 1 enters `stage_pred[0]`.
- R4: On a strobe with a zero loop count and an epilog count greater than 1, the epilog count decrements by 1 and a 0 enters `stage_pred[0]`.
- R5: On a strobe with a zero loop count and an epilog count of 0 or 1, the branch falls through. The epilog count becomes 0, and `stage_pred` and `rot_base` keep their values.
- R6: Each taken branch sets `rot_base` to (`rot_base` − 1) mod `N_ROT_GR`, so a base of 0 wraps to `N_ROT_GR`−1.
- R7: On the same edge as R6, stage predicate i (`stage_pred[i]`, architectural predicate 16+i) moves to position i+1. The top bit is discarded.
- R8: A write enable loads its register at the next edge. If the enable is asserted in a strobe cycle, the write wins for that register, and the branch still updates the other registers, including `rot_base`.
- R9: In a cycle with no strobe and no write, no state changes.
- R10: Loading loop count L and epilog count E yields exactly L + max(E−1, 0) taken branches before the first fall-through. The predicate bit shifted in at the m-th taken branch (counting from 0) is 1 exactly when m < L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lc_wr_en | input | 1 | Load the loop counter |
| lc_wr_data | input | LC_W | New loop count |
| ec_wr_en | input | 1 | Load the epilog counter |
| ec_wr_data | input | EC_W | New epilog count |
| pred_wr_en | input | 1 | Load the rotating predicate bank |
| pred_wr_data | input | N_ROT_PRED | New predicates, bit i = predicate 16+i |
| br_strobe | input | 1 | One execution of the loop-closing branch |
| br_taken | output | 1 | Branch decision for the current strobe |
| rot_base | output | $clog2(N_ROT_GR) | Rotating register base |
| stage_pred | output | N_ROT_PRED | Stage predicates, bit i = predicate 16+i |

## Verification
The assertions assume that the branch strobe is a plain level sampled at each edge. They make no assumption about its spacing, so back-to-back strobes and isolated strobes are equally legal. Their shift and rotation properties apply only when no predicate write coincides with the strobe, because R8 lets a write override the shift. The stimulus changes every input half a cycle away from the sampling edge. Coincident writes and strobes appear only in the directed priority cases, and the sweep keeps loop counts small so that each run drains to its fall-through well within the run budget.

// File: rtl/msl_pkg.sv
package msl_pkg;
  // Decrement a rotating base with wrap-around inside a region of the given size.
  function automatic int unsigned rot_dec(input int unsigned base, input int unsigned size);
    return (base == 0) ? size - 1 : base - 1;
  endfunction
endpackage

// File: rtl/msl_count_unit.sv
module msl_count_unit #(
  parameter int LC_W = 16,
  parameter int EC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            lc_wr_en,
  input  logic [LC_W-1:0] lc_wr_data,
  input  logic            ec_wr_en,
  input  logic [EC_W-1:0] ec_wr_data,
  output logic            taken,
  output logic            kernel_bit,
  output logic [LC_W-1:0] lc_q,
  output logic [EC_W-1:0] ec_q
);
  logic            lc_busy;
  logic            ec_more;
  logic [LC_W-1:0] lc_n;
  logic [EC_W-1:0] ec_n;

  assign lc_busy    = (lc_q != '0);
  assign ec_more    = (ec_q > EC_W'(1));
  assign taken      = strobe && (lc_busy || ec_more);
  assign kernel_bit = lc_busy;

  always_comb begin
    lc_n = lc_q;
    ec_n = ec_q;
    if (strobe) begin
      if (lc_busy)
        lc_n = lc_q - LC_W'(1);
      else if (ec_q != '0)
        ec_n = ec_q - EC_W'(1);
    end
    if (lc_wr_en) lc_n = lc_wr_data;
    if (ec_wr_en) ec_n = ec_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0;
      ec_q <= '0;
    end else begin
      lc_q <= lc_n;
      ec_q <= ec_n;
    end
  end
endmodule

// File: rtl/msl_pred_ring.sv
module msl_pred_ring #(
  parameter int NP = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          in_bit,
  input  logic          wr_en,
  input  logic [NP-1:0] wr_data,
  output logic [NP-1:0] q
);
  logic [NP-1:0] q_n;

  generate
    genvar i;
    for (i = 0; i < NP; i++) begin : g_bit
      if (i == 0) begin : g_head
        always_comb q_n[i] = wr_en ? wr_data[i] : (shift ? in_bit : q[i]);
      end else begin : g_tail
        always_comb q_n[i] = wr_en ? wr_data[i] : (shift ? q[i-1] : q[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/msl_rename_base.sv
module msl_rename_base #(
  parameter int N_ROT_GR = 96,
  localparam int BASE_W = $clog2(N_ROT_GR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [BASE_W-1:0] base
);
  import msl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base <= '0;
    else if (advance)
      base <= BASE_W'(rot_dec(int'(base), N_ROT_GR));
  end
endmodule

// File: rtl/msl_loop_ctrl.sv
module msl_loop_ctrl #(
  parameter int LC_W       = 16,
  parameter int EC_W       = 6,
  parameter int N_ROT_PRED = 48,
  parameter int N_ROT_GR   = 96,
  localparam int BASE_W    = $clog2(N_ROT_GR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lc_wr_en,
  input  logic [LC_W-1:0]       lc_wr_data,
  input  logic                  ec_wr_en,
  input  logic [EC_W-1:0]       ec_wr_data,
  input  logic                  pred_wr_en,
  input  logic [N_ROT_PRED-1:0] pred_wr_data,
  input  logic                  br_strobe,
  output logic                  br_taken,
  output logic [BASE_W-1:0]     rot_base,
  output logic [N_ROT_PRED-1:0] stage_pred
);
  logic            kernel_bit;
  logic [LC_W-1:0] lc_q;
  logic [EC_W-1:0] ec_q;

  msl_count_unit #(.LC_W(LC_W), .EC_W(EC_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (br_strobe),
    .lc_wr_en   (lc_wr_en),
    .lc_wr_data (lc_wr_data),
    .ec_wr_en   (ec_wr_en),
    .ec_wr_data (ec_wr_data),
    .taken      (br_taken),
    .kernel_bit (kernel_bit),
    .lc_q       (lc_q),
    .ec_q       (ec_q)
  );

  msl_pred_ring #(.NP(N_ROT_PRED)) u_pred (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (br_taken),
    .in_bit  (kernel_bit),
    .wr_en   (pred_wr_en),
    .wr_data (pred_wr_data),
    .q       (stage_pred)
  );

  msl_rename_base #(.N_ROT_GR(N_ROT_GR)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (br_taken),
    .base    (rot_base)
  );
endmodule

// File: rtl/msl_loop_ctrl_chk.sv
module msl_loop_ctrl_chk #(
  parameter int LC_W       = 16,
  parameter int EC_W       = 6,
  parameter int N_ROT_PRED = 48,
  parameter int N_ROT_GR   = 96,
  localparam int BASE_W    = $clog2(N_ROT_GR)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lc_wr_en,
  input logic                  ec_wr_en,
  input logic                  pred_wr_en,
  input logic                  br_strobe,
  input logic                  br_taken,
  input logic [BASE_W-1:0]     rot_base,
  input logic [N_ROT_PRED-1:0] stage_pred,
  input logic [LC_W-1:0]       lc_q,
  input logic [EC_W-1:0]       ec_q
);
  logic idle;
  assign idle = !br_strobe && !lc_wr_en && !ec_wr_en && !pred_wr_en;

  // R2
  taken_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_strobe |-> !br_taken);

  // R3
  kernel_lc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && lc_q != '0 && !lc_wr_en) |=> lc_q == $past(lc_q) - LC_W'(1));

  // R3
  kernel_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && lc_q != '0 && !pred_wr_en) |=> stage_pred[0]);

  // R4
  epilog_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && lc_q == '0 && ec_q > EC_W'(1) && !pred_wr_en) |=> !stage_pred[0]);

  // R5
  fall_through_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_strobe && !br_taken && !pred_wr_en) |=> ($stable(stage_pred) && $stable(rot_base)));

  // R6
  base_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> rot_base == (($past(rot_base) == '0) ? BASE_W'(N_ROT_GR - 1)
                                                      : $past(rot_base) - BASE_W'(1)));

  // R7
  pred_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !pred_wr_en) |=> stage_pred[N_ROT_PRED-1:1] == $past(stage_pred[N_ROT_PRED-2:0]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(rot_base) && $stable(stage_pred) && $stable(lc_q) && $stable(ec_q)));
endmodule

bind msl_loop_ctrl msl_loop_ctrl_chk #(
  .LC_W(LC_W), .EC_W(EC_W), .N_ROT_PRED(N_ROT_PRED), .N_ROT_GR(N_ROT_GR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lc_wr_en   (lc_wr_en),
  .ec_wr_en   (ec_wr_en),
  .pred_wr_en (pred_wr_en),
  .br_strobe  (br_strobe),
  .br_taken   (br_taken),
  .rot_base   (rot_base),
  .stage_pred (stage_pred),
  .lc_q       (lc_q),
  .ec_q       (ec_q)
);

// File: tb/msl_loop_ctrl_tb.sv
`timescale 1ns/1ps
module msl_loop_ctrl_tb;
  localparam int LC_W = 16;
  localparam int EC_W = 6;
  localparam int NP   = 48;
  localparam int NGR  = 96;
  localparam int BW   = $clog2(NGR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lc_wr_en = 1'b0;
  logic [LC_W-1:0] lc_wr_data = '0;
  logic          ec_wr_en = 1'b0;
  logic [EC_W-1:0] ec_wr_data = '0;
  logic          pred_wr_en = 1'b0;
  logic [NP-1:0] pred_wr_data = '0;
  logic          br_strobe = 1'b0;
  logic          br_taken;
  logic [BW-1:0] rot_base;
  logic [NP-1:0] stage_pred;

  int checks = 0;
  int errors = 0;
  int exp_base = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msl_loop_ctrl #(.LC_W(LC_W), .EC_W(EC_W), .N_ROT_PRED(NP), .N_ROT_GR(NGR)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lc_wr_en(lc_wr_en), .lc_wr_data(lc_wr_data),
    .ec_wr_en(ec_wr_en), .ec_wr_data(ec_wr_data),
    .pred_wr_en(pred_wr_en), .pred_wr_data(pred_wr_data),
    .br_strobe(br_strobe), .br_taken(br_taken),
    .rot_base(rot_base), .stage_pred(stage_pred)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected predicates after k taken branches from pattern init with loop count L.
  function automatic logic [NP-1:0] exp_pred(input logic [NP-1:0] init, input int L, input int k);
    logic [NP-1:0] r;
    for (int j = 0; j < NP; j++) begin
      if (j < k) r[j] = ((k - 1 - j) < L);
      else       r[j] = init[j-k];
    end
    return r;
  endfunction

  task automatic load(input int L, input int E, input logic [NP-1:0] p);
    @(negedge clk);
    lc_wr_en = 1'b1; lc_wr_data = LC_W'(L);
    ec_wr_en = 1'b1; ec_wr_data = EC_W'(E);
    pred_wr_en = 1'b1; pred_wr_data = p;
    @(negedge clk);
    lc_wr_en = 1'b0; ec_wr_en = 1'b0; pred_wr_en = 1'b0;
  endtask

  // One strobe cycle; returns the sampled decision.
  task automatic branch(output logic tk);
    @(negedge clk);
    br_strobe = 1'b1;
    #1 tk = br_taken;
    @(negedge clk);
    br_strobe = 1'b0;
  endtask

  // Run a full loop with counts L/E and initial pattern p, checking every branch.
  task automatic run_loop(input int L, input int E, input logic [NP-1:0] p);
    int total;
    logic tk;
    logic [NP-1:0] last;
    total = L + ((E > 1) ? E - 1 : 0);
    load(L, E, p);
    for (int k = 0; k < total; k++) begin
      branch(tk);
      chk((k < L) ? "R3/R2 kernel taken" : "R4/R2 epilog taken", 64'(tk), 64'(1));
      exp_base = (exp_base == 0) ? NGR - 1 : exp_base - 1;
      chk("R6 base", 64'(rot_base), 64'(exp_base));
      chk("R7/R10 preds", 64'(stage_pred), 64'(exp_pred(p, L, k + 1)));
    end
    last = exp_pred(p, L, total);
    branch(tk);
    chk("R5/R10 fall-through", 64'(tk), 64'(0));
    chk("R5 base held", 64'(rot_base), 64'(exp_base));
    chk("R5 preds held", 64'(stage_pred), 64'(last));
    branch(tk);
    chk("R5 second fall-through", 64'(tk), 64'(0));
    chk("R5 preds still held", 64'(stage_pred), 64'(last));
  endtask

  initial begin
    logic tk;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 base", 64'(rot_base), 64'(0));
    chk("R1 preds", 64'(stage_pred), 64'(0));
    chk("R2 no strobe", 64'(br_taken), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    branch(tk);
    chk("R1 counters zero", 64'(tk), 64'(0));
    chk("R1 base after strobe", 64'(rot_base), 64'(0));

    // R10 sweep over small counts
    for (int L = 0; L <= 9; L++)
      for (int E = 0; E <= 5; E++)
        run_loop(L, E, (E == 3) ? 48'h8000_0000_0A51 : 48'h1);

    // R10 full example: 202 taken branches, crosses the base wrap (R6)
    run_loop(199, 4, 48'h1);

    // R9 idle cycles change nothing
    load(2, 2, 48'h3);
    repeat (5) @(negedge clk);
    chk("R9 preds idle", 64'(stage_pred), 64'(48'h3));
    chk("R9 base idle", 64'(rot_base), 64'(exp_base));

    // R8 loop-count write wins over the strobe decrement
    @(negedge clk);
    br_strobe = 1'b1; lc_wr_en = 1'b1; lc_wr_data = LC_W'(5);
    #1 chk("R8 taken with write", 64'(br_taken), 64'(1));
    @(negedge clk);
    br_strobe = 1'b0; lc_wr_en = 1'b0;
    exp_base = (exp_base == 0) ? NGR - 1 : exp_base - 1;
    chk("R8 base still rotates", 64'(rot_base), 64'(exp_base));
    chk("R8 preds shifted", 64'(stage_pred), 64'(48'h7));
    for (int k = 0; k < 6; k++) begin
      branch(tk);
      chk("R8 reloaded count", 64'(tk), 64'(1));
    end
    exp_base = (exp_base + NGR - 6) % NGR;
    branch(tk);
    chk("R8 drained", 64'(tk), 64'(0));

    // R8 predicate write wins over the shift, base still rotates
    @(negedge clk);
    lc_wr_en = 1'b1; lc_wr_data = LC_W'(1);
    @(negedge clk);
    lc_wr_en = 1'b0;
    br_strobe = 1'b1; pred_wr_en = 1'b1; pred_wr_data = 48'h0000_0000_00F0;
    @(negedge clk);
    br_strobe = 1'b0; pred_wr_en = 1'b0;
    exp_base = (exp_base == 0) ? NGR - 1 : exp_base - 1;
    chk("R8 pred write wins", 64'(stage_pred), 64'(48'hF0));
    chk("R8 base with pred write", 64'(rot_base), 64'(exp_base));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule